// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block is a small fully associative table of recently taken branches. Each entry holds a branch instruction address, the address that branch last jumped to, and a two-bit saturating history. The first decode stage presents an instruction address on the lookup side. In the same cycle the block reports whether the address is known, whether the branch is predicted taken, and the target to redirect fetch to.

The execute stage reports each resolved branch on the update side, with its real direction and real target. A resolved branch that is already in the table moves its history one step toward the observed direction. A branch that resolves taken and is not in the table claims the entry under a round-robin victim pointer. A branch that resolves not taken and is not in the table changes nothing. The table state is held in registers, so a lookup that meets an update in the same cycle sees the state from before that update.

Top module: `btb_pred`

## Requirements
- R1: After reset every entry is empty, so every lookup misses.
- R2: A lookup that misses, or any cycle with `lk_valid` low, gives `lk_hit`=0, `lk_taken`=0 and `lk_target`=0.
- R3: A lookup that hits gives `lk_hit`=1 and the stored target on `lk_target`. `lk_taken` equals bit 1 of the entry's history: history 10 or 11 predicts taken, and 00 or 01 predicts not taken.
- R4: An update that resolves taken and misses allocates an entry holding the address, the target and history 11 (strongly taken). It is visible to lookups from the next cycle on.
- R5: An update that resolves not taken and misses leaves every entry and the victim pointer unchanged.
- R6: An update that resolves taken and hits with the same target increments the history, which saturates at 11.
- R7: An update that resolves not taken and hits decrements the history, which saturates at 00.
- R8: Allocation takes entries 0, 1, 2 and onward in turn, wrapping after the last. With 16 entries, the 17th allocation evicts the branch allocated first.
- R9: When a lookup and an update touch the same address in one cycle, the lookup returns the table contents from before the update.
- R10: An update that resolves taken and hits with a target different from the stored one writes the new target and sets the history to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| lk_valid | input | 1 | Lookup request from first decode stage |
| lk_pc | input | PC_W | Instruction address to look up |
| lk_hit | output | 1 | Address found in table |
| lk_taken | output | 1 | Predicted taken, redirect fetch |
| lk_target | output | TGT_W | Predicted target (0 on miss) |
| up_valid | input | 1 | Resolved branch from execute stage |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual direction, 1 = taken |
| up_target | input | TGT_W | Actual target of the branch |

## Verification
A lookup and an update can fall in the same cycle, and the case that matters is when both name the same branch. The bench provokes this in directed steps: a lookup meets the allocating update of its own address, and later a lookup meets history steps on that entry. It also produces many such collisions at random, by drawing both addresses from a small shared pool. The result is judged against a bench model that checks the lookup before it applies that cycle's update, so any forwarding of the new state is reported as a failure.

// File: rtl/btb_pkg.sv
package btb_pkg;

   typedef enum logic [1:0] {
      HIST_SNT = 2'b00,
      HIST_WNT = 2'b01,
      HIST_WT  = 2'b10,
      HIST_ST  = 2'b11
   } hist_e;

   // saturating one-step move toward the observed direction
   function automatic hist_e hist_step(input hist_e h, input logic taken);
      hist_e r;
      r = h;
      if (taken) begin
         if (h != HIST_ST) r = hist_e'(h + 2'd1);
      end else begin
         if (h != HIST_SNT) r = hist_e'(h - 2'd1);
      end
      return r;
   endfunction

endpackage

// File: rtl/btb_entry.sv
module btb_entry
   import btb_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int TGT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_i,
   input  logic             upd_i,
   input  logic             taken_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic [TGT_W-1:0] tgt_i,
   output logic             valid_o,
   output logic [PC_W-1:0]  tag_o,
   output logic [TGT_W-1:0] tgt_o,
   output logic [1:0]       hist_o
);

   logic             valid_q;
   logic [PC_W-1:0]  tag_q;
   logic [TGT_W-1:0] tgt_q;
   hist_e            hist_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
         tgt_q   <= '0;
         hist_q  <= HIST_SNT;
      end else if (alloc_i) begin
         valid_q <= 1'b1;
         tag_q   <= pc_i;
         tgt_q   <= tgt_i;
         hist_q  <= HIST_ST;
      end else if (upd_i) begin
         if (taken_i && (tgt_q != tgt_i)) begin
            tgt_q  <= tgt_i;
            hist_q <= HIST_ST;
         end else begin
            hist_q <= hist_step(hist_q, taken_i);
         end
      end
   end

   assign valid_o = valid_q;
   assign tag_o   = tag_q;
   assign tgt_o   = tgt_q;
   assign hist_o  = hist_q;

   AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !alloc_i && taken_i && tgt_q == tgt_i && hist_q == HIST_ST) |=> hist_q == HIST_ST); // R6
   AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !alloc_i && !taken_i && hist_q == HIST_SNT) |=> hist_q == HIST_SNT); // R7
   AST_NEW_TGT: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !alloc_i && taken_i && tgt_q != tgt_i) |=> hist_q == HIST_ST); // R10

endmodule

// File: rtl/btb_match.sv
module btb_match #(
   parameter int ENTRIES = 16,
   parameter int PC_W    = 32
) (
   input  logic [ENTRIES-1:0]           valid_i,
   input  logic [ENTRIES-1:0][PC_W-1:0] tags_i,
   input  logic [PC_W-1:0]              pc_i,
   output logic [ENTRIES-1:0]           hit_o
);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hit_o[i] = valid_i[i] && (tags_i[i] == pc_i);
   end

endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   output logic [IDX_W-1:0] ptr_o
);

   localparam int          LAST  = ENTRIES - 1;
   localparam logic [IDX_W-1:0] LAST_V = IDX_W'(LAST);
   localparam bit          POW2  = (ENTRIES == (1 << IDX_W));

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] ptr_nx;

   if (POW2) begin : g_wrap_free
      assign ptr_nx = ptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_nx = (ptr_q == LAST_V) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     ptr_q <= '0;
      else if (adv_i) ptr_q <= ptr_nx;
   end

   assign ptr_o = ptr_q;

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST_V); // R8

endmodule

// File: rtl/btb_pred.sv
module btb_pred
   import btb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int PC_W    = 32,
   parameter int TGT_W   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [PC_W-1:0]  lk_pc,
   output logic             lk_hit,
   output logic             lk_taken,
   output logic [TGT_W-1:0] lk_target,
   input  logic             up_valid,
   input  logic [PC_W-1:0]  up_pc,
   input  logic             up_taken,
   input  logic [TGT_W-1:0] up_target
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("btb_pred: ENTRIES must be at least 2");
   end
   if (PC_W < 1 || TGT_W < 1) begin : g_bad_width
      $error("btb_pred: address widths must be positive");
   end

   logic [ENTRIES-1:0]            valid_v;
   logic [ENTRIES-1:0][PC_W-1:0]  tag_v;
   logic [ENTRIES-1:0][TGT_W-1:0] tgt_v;
   logic [ENTRIES-1:0][1:0]       hist_v;
   logic [ENTRIES-1:0]            lk_hitv;
   logic [ENTRIES-1:0]            up_hitv;
   logic [IDX_W-1:0]              vptr;
   logic                          up_any;
   logic                          alloc;

   btb_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_lk_match (
      .valid_i(valid_v), .tags_i(tag_v), .pc_i(lk_pc), .hit_o(lk_hitv));

   btb_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_up_match (
      .valid_i(valid_v), .tags_i(tag_v), .pc_i(up_pc), .hit_o(up_hitv));

   assign up_any = |up_hitv;
   assign alloc  = up_valid && up_taken && !up_any;

   btb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .clk(clk), .rst_n(rst_n), .adv_i(alloc), .ptr_o(vptr));

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      btb_entry #(.PC_W(PC_W), .TGT_W(TGT_W)) u_ent (
         .clk    (clk),
         .rst_n  (rst_n),
         .alloc_i(alloc && (vptr == IDX_W'(i))),
         .upd_i  (up_valid && up_hitv[i]),
         .taken_i(up_taken),
         .pc_i   (up_pc),
         .tgt_i  (up_target),
         .valid_o(valid_v[i]),
         .tag_o  (tag_v[i]),
         .tgt_o  (tgt_v[i]),
         .hist_o (hist_v[i]));
   end

   always_comb begin
      lk_hit    = 1'b0;
      lk_taken  = 1'b0;
      lk_target = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_valid && lk_hitv[i]) begin
            lk_hit    = 1'b1;
            lk_taken  = lk_taken | hist_v[i][1];
            lk_target = lk_target | tgt_v[i];
         end
      end
   end

   AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (!lk_taken && lk_target == '0)); // R2
   AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hitv)); // R4
   AST_ALLOC_STRONG: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |=> (valid_v[$past(vptr)] && hist_v[$past(vptr)] == 2'b11)); // R4
   AST_NT_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken && !up_any) |=> ($stable(valid_v) && $stable(vptr))); // R5
   AST_VICTIM_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |=> vptr != $past(vptr)); // R8

endmodule

// File: tb/btb_pred_tb.sv
module btb_pred_tb;

   localparam int N     = 16;
   localparam int PC_W  = 32;
   localparam int TGT_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lk_valid = 1'b0;
   logic [PC_W-1:0]  lk_pc = '0;
   logic             lk_hit;
   logic             lk_taken;
   logic [TGT_W-1:0] lk_target;
   logic             up_valid = 1'b0;
   logic [PC_W-1:0]  up_pc = '0;
   logic             up_taken = 1'b0;
   logic [TGT_W-1:0] up_target = '0;

   always #2 clk = ~clk;

   btb_pred #(.ENTRIES(N), .PC_W(PC_W), .TGT_W(TGT_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_pc(lk_pc),
      .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target));

   // reference model
   bit               m_valid [N];
   logic [PC_W-1:0]  m_tag   [N];
   logic [TGT_W-1:0] m_tgt   [N];
   int               m_hist  [N];
   int               m_ptr;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   function automatic int m_find(input logic [PC_W-1:0] pc);
      for (int i = 0; i < N; i++)
         if (m_valid[i] && m_tag[i] == pc) return i;
      return -1;
   endfunction

   task automatic m_clear();
      for (int i = 0; i < N; i++) begin
         m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_hist[i] = 0;
      end
      m_ptr = 0;
   endtask

   task automatic m_update(input logic [PC_W-1:0] pc, input bit tk, input logic [TGT_W-1:0] tg);
      int k;
      k = m_find(pc);
      if (k >= 0) begin
         if (tk && m_tgt[k] != tg) begin
            m_tgt[k] = tg; m_hist[k] = 3;                 // R10
         end else if (tk) begin
            if (m_hist[k] < 3) m_hist[k]++;               // R6
         end else begin
            if (m_hist[k] > 0) m_hist[k]--;               // R7
         end
      end else if (tk) begin                            // R4, R8
         m_valid[m_ptr] = 1'b1; m_tag[m_ptr] = pc; m_tgt[m_ptr] = tg; m_hist[m_ptr] = 3;
         m_ptr = (m_ptr + 1) % N;
      end                                               // R5: not-taken miss: nothing
   endtask

   task automatic check_bit(input string req, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   // one cycle: drive at negedge, check lookup against pre-update model, then apply update
   task automatic step(input bit lv, input logic [PC_W-1:0] lpc,
                       input bit uv, input logic [PC_W-1:0] upc, input bit ut,
                       input logic [TGT_W-1:0] utg, input string req);
      int k;
      bit eh, et;
      logic [TGT_W-1:0] eg;
      @(negedge clk);
      lk_valid = lv; lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut; up_target = utg;
      #1;
      k  = m_find(lpc);
      eh = lv && (k >= 0);
      et = eh && (m_hist[k] >= 2);
      eg = eh ? m_tgt[k] : '0;
      n_tests++;
      if (lk_hit !== eh || lk_taken !== et || lk_target !== eg) begin
         n_fail++;
         $display("FAIL %s lookup pc=%h actual hit=%0b taken=%0b tgt=%h expected hit=%0b taken=%0b tgt=%h",
                  req, lpc, lk_hit, lk_taken, lk_target, eh, et, eg);
      end
      if (uv) m_update(upc, ut, utg);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; lk_valid = 1'b0; up_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_clear();
   endtask

   localparam logic [PC_W-1:0]  PA = 32'h0000_4000;
   localparam logic [TGT_W-1:0] T1 = 32'h0000_0100;
   localparam logic [TGT_W-1:0] T2 = 32'h0000_0200;

   initial begin
      #400000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0000_5EED));
      m_clear();
      do_reset();

      // R1: empty after reset
      step(1, PA, 0, '0, 0, '0, "R1");
      step(1, 32'h0000_1234, 0, '0, 0, '0, "R1");
      // R5: not-taken miss changes nothing
      step(0, '0, 1, PA, 0, T1, "R5");
      step(1, PA, 0, '0, 0, '0, "R5");
      // R9: allocate while looking up the same address -> old (miss)
      step(1, PA, 1, PA, 1, T1, "R9");
      // R4: allocated strongly taken
      step(1, PA, 0, '0, 0, '0, "R4");
      check_bit("R4", "taken after alloc", lk_taken, 1'b1);
      // R2: lk_valid low gives nothing
      step(0, PA, 0, '0, 0, '0, "R2");
      // R7: decrement with same-cycle lookups (R9)
      step(1, PA, 1, PA, 0, T1, "R9");   // 11 -> 10
      step(1, PA, 1, PA, 0, T1, "R7");   // 10 -> 01, still predicts taken here
      step(1, PA, 0, '0, 0, '0, "R3");   // 01: hit, not taken
      check_bit("R3", "weak not taken", lk_taken, 1'b0);
      step(1, PA, 1, PA, 0, T1, "R7");   // -> 00
      step(1, PA, 1, PA, 0, T1, "R7");   // stays 00
      step(1, PA, 1, PA, 1, T1, "R7");   // -> 01
      step(1, PA, 1, PA, 1, T1, "R6");   // -> 10
      step(1, PA, 1, PA, 1, T1, "R6");   // -> 11
      step(1, PA, 1, PA, 1, T1, "R6");   // stays 11
      step(1, PA, 1, PA, 0, T1, "R6");   // -> 10
      step(1, PA, 0, '0, 0, '0, "R6");
      check_bit("R6", "saturated high then one down", lk_taken, 1'b1);
      // R10: new target resets history to 11
      step(0, '0, 1, PA, 0, T1, "R10");  // -> 01
      step(1, PA, 1, PA, 1, T2, "R10");  // new target
      step(1, PA, 1, PA, 0, T2, "R10");  // 11 -> 10
      step(1, PA, 0, '0, 0, '0, "R10");
      check_bit("R10", "taken after retarget", lk_taken, 1'b1);

      // R8: round-robin replacement
      do_reset();
      for (int i = 0; i < N + 1; i++)
         step(0, '0, 1, 32'h0000_8000 + 32'(i * 4), 1, 32'h0000_9000 + 32'(i), "R8");
      step(1, 32'h0000_8000, 0, '0, 0, '0, "R8");
      check_bit("R8", "first allocated evicted", lk_hit, 1'b0);
      step(1, 32'h0000_8004, 0, '0, 0, '0, "R8");
      check_bit("R8", "second allocated kept", lk_hit, 1'b1);
      step(1, 32'h0000_8040, 0, '0, 0, '0, "R8");

      // random traffic over a small shared address pool
      for (int c = 0; c < 4000; c++) begin
         logic [PC_W-1:0] lp, upa;
         lp  = 32'h0000_1000 + 32'(($urandom % 24) * 4);
         upa = ($urandom % 3 == 0) ? lp : 32'h0000_1000 + 32'(($urandom % 24) * 4);
         step($urandom % 4 != 0, lp, $urandom % 3 != 0, upa, $urandom % 2 == 1,
              32'h0000_2000 + 32'($urandom % 3), "R3");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule